// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block works out where a small processor core fetches next after a flow-control instruction, and how many clock cycles that instruction costs. Each cycle the core may present one operation class with its operands: the current program counter, the raw relative-offset field, an absolute target, the 16-bit Z pointer, an address popped from the stack, the 8-bit status register with a bit selector, a tested bit value, and a flag telling whether the instruction after this one is two words long.

One clock edge after an accepted request, the block presents the next program counter, whether control flow left the sequential path, the cycle cost, and a pulse that tells the core to set its global interrupt-enable flag. The return stack memory and instruction fetch stay outside. All program-counter arithmetic is modulo 2^PC_W.

Top module: `pc_nxt_unit`

## Requirements
- R1: Relative jump (op 0) and relative call (op 1) give pc + sext12(off) + 1, with taken high. The jump costs 2 cycles and the call costs 3.
- R2: Indirect jump (op 2) and indirect call (op 3) give the low PC_W bits of the Z pointer, with taken high. The jump costs 2 cycles and the call costs 3.
- R3: Absolute jump (op 4) costs 3 cycles and absolute call (op 5) costs 4. Both go to the absolute target with taken high.
- R4: Return (op 6) goes to the popped address, costs 4 cycles, sets taken and keeps irq_en_set_o low.
- R5: Return from interrupt (op 7) does the same as R4 and also raises irq_en_set_o.
- R6: Branch-if-set (op 8) and branch-if-clear (op 9) test sreg[sel]. C is bit 0, Z is bit 1 and T is bit 6. Same-or-higher is op 9 on bit 0, and lower is op 8 on bit 0. Only the low 7 bits of the offset are used, sign-extended. A taken branch gives pc + sext7 + 1 and costs 2. A branch not taken gives pc + 1, costs 1 and has taken low.
- R7: Signed greater-or-equal (op 10) branches when N XOR V is 0, with N at bit 2 and V at bit 3. Signed less-than (op 11) branches when N XOR V is 1. Cost and targets are as in R6.
- R8: Skip-if-bit-set (op 12) and skip-if-bit-clear (op 13) test the tested bit. When the test holds, the result is pc + 2 with cost 2, or pc + 3 with cost 3 when the next instruction is two words. Otherwise the result is pc + 1 with cost 1 and taken low.
- R9: Results appear on the edge after valid_i. valid_o is high only in the cycle after an accepted request. Reset clears every output to zero.
- R10: Op codes 14 and 15 give pc + 1, cost 1, taken low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present |
| op_i | input | 4 | Operation class |
| pc_i | input | PC_W | Current program counter |
| off_i | input | JREL_W | Raw relative-offset field |
| abs_i | input | PC_W | Absolute target |
| zptr_i | input | Z_W | Z pointer |
| ret_i | input | PC_W | Address popped from the stack |
| sreg_i | input | 8 | Status register |
| sel_i | input | 3 | Status bit selector |
| tbit_i | input | 1 | Tested bit for skips |
| two_word_i | input | 1 | Next instruction is two words |
| valid_o | output | 1 | Result present |
| next_pc_o | output | PC_W | Next program counter |
| taken_o | output | 1 | Left the sequential path |
| cycles_o | output | 3 | Cycle cost |
| irq_en_set_o | output | 1 | Set global interrupt enable |

## Verification
The bench builds the block with its defaults: a 14-bit program counter, 12-bit jump offsets, 7-bit branch offsets and a 16-bit Z pointer. A 14-bit counter lets a backward jump of -2048 from address 0 wrap below zero, and lets a two-word skip at the top address wrap to the bottom. Because the Z pointer is wider than the counter, its dropped upper bits are exercised. Filling the upper five offset bits on a branch shows that only seven bits take part.

// File: rtl/pc_nxt_pkg.sv
package pc_nxt_pkg;

  typedef enum logic [3:0] {
    OP_RJMP  = 4'd0,
    OP_RCALL = 4'd1,
    OP_IJMP  = 4'd2,
    OP_ICALL = 4'd3,
    OP_JMP   = 4'd4,
    OP_CALL  = 4'd5,
    OP_RET   = 4'd6,
    OP_RETI  = 4'd7,
    OP_BRSET = 4'd8,
    OP_BRCLR = 4'd9,
    OP_BRGE  = 4'd10,
    OP_BRLT  = 4'd11,
    OP_SKSET = 4'd12,
    OP_SKCLR = 4'd13
  } pc_op_e;

  typedef enum logic [2:0] {
    SRC_SEQ,
    SRC_JREL,
    SRC_BREL,
    SRC_Z,
    SRC_ABS,
    SRC_RET,
    SRC_SKIP1,
    SRC_SKIP2
  } pc_src_e;

  localparam int SR_N = 2;
  localparam int SR_V = 3;

endpackage

// File: rtl/pc_nxt_target.sv
module pc_nxt_target #(
  parameter int PC_W   = 14,
  parameter int JREL_W = 12,
  parameter int BREL_W = 7
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [JREL_W-1:0] off_i,
  output logic [PC_W-1:0]   jrel_o,
  output logic [PC_W-1:0]   brel_o,
  output logic [PC_W-1:0]   seq_o,
  output logic [PC_W-1:0]   skip1_o,
  output logic [PC_W-1:0]   skip2_o
);

  logic [PC_W-1:0] jrel_ext, brel_ext;

  generate
    if (PC_W > JREL_W) begin : g_jext
      assign jrel_ext = {{(PC_W-JREL_W){off_i[JREL_W-1]}}, off_i};
    end else begin : g_jtrunc
      assign jrel_ext = off_i[PC_W-1:0];
    end

    if (PC_W > BREL_W) begin : g_bext
      assign brel_ext = {{(PC_W-BREL_W){off_i[BREL_W-1]}}, off_i[BREL_W-1:0]};
    end else begin : g_btrunc
      assign brel_ext = off_i[PC_W-1:0];
    end
  endgenerate

  assign seq_o   = pc_i + PC_W'(1);
  assign skip1_o = pc_i + PC_W'(2);
  assign skip2_o = pc_i + PC_W'(3);
  assign jrel_o  = seq_o + jrel_ext;
  assign brel_o  = seq_o + brel_ext;

endmodule

// File: rtl/pc_nxt_cond.sv
module pc_nxt_cond
  import pc_nxt_pkg::*;
(
  input  pc_op_e     op_i,
  input  logic [7:0] sreg_i,
  input  logic [2:0] sel_i,
  input  logic       tbit_i,
  output logic       cond_o
);

  logic sel_bit, signed_lt;

  assign sel_bit   = sreg_i[sel_i];
  assign signed_lt = sreg_i[SR_N] ^ sreg_i[SR_V];

  always_comb begin
    unique case (op_i)
      OP_BRSET: cond_o = sel_bit;
      OP_BRCLR: cond_o = !sel_bit;
      OP_BRGE:  cond_o = !signed_lt;
      OP_BRLT:  cond_o = signed_lt;
      OP_SKSET: cond_o = tbit_i;
      OP_SKCLR: cond_o = !tbit_i;
      default:  cond_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pc_nxt_cost.sv
module pc_nxt_cost
  import pc_nxt_pkg::*;
(
  input  pc_op_e     op_i,
  input  logic       cond_i,
  input  logic       two_word_i,
  output pc_src_e    src_o,
  output logic [2:0] cycles_o,
  output logic       taken_o,
  output logic       irq_o
);

  always_comb begin
    src_o    = SRC_SEQ;
    cycles_o = 3'd1;
    taken_o  = 1'b0;
    irq_o    = 1'b0;
    case (op_i)
      OP_RJMP:  begin src_o = SRC_JREL; cycles_o = 3'd2; taken_o = 1'b1; end
      OP_RCALL: begin src_o = SRC_JREL; cycles_o = 3'd3; taken_o = 1'b1; end
      OP_IJMP:  begin src_o = SRC_Z;    cycles_o = 3'd2; taken_o = 1'b1; end
      OP_ICALL: begin src_o = SRC_Z;    cycles_o = 3'd3; taken_o = 1'b1; end
      OP_JMP:   begin src_o = SRC_ABS;  cycles_o = 3'd3; taken_o = 1'b1; end
      OP_CALL:  begin src_o = SRC_ABS;  cycles_o = 3'd4; taken_o = 1'b1; end
      OP_RET:   begin src_o = SRC_RET;  cycles_o = 3'd4; taken_o = 1'b1; end
      OP_RETI:  begin
        src_o = SRC_RET; cycles_o = 3'd4; taken_o = 1'b1; irq_o = 1'b1;
      end
      OP_BRSET, OP_BRCLR, OP_BRGE, OP_BRLT: begin
        if (cond_i) begin
          src_o = SRC_BREL; cycles_o = 3'd2; taken_o = 1'b1;
        end
      end
      OP_SKSET, OP_SKCLR: begin
        if (cond_i) begin
          taken_o = 1'b1;
          if (two_word_i) begin
            src_o = SRC_SKIP2; cycles_o = 3'd3;
          end else begin
            src_o = SRC_SKIP1; cycles_o = 3'd2;
          end
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pc_nxt_unit.sv
module pc_nxt_unit
  import pc_nxt_pkg::*;
#(
  parameter int PC_W   = 14,
  parameter int JREL_W = 12,
  parameter int BREL_W = 7,
  parameter int Z_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [JREL_W-1:0] off_i,
  input  logic [PC_W-1:0]   abs_i,
  input  logic [Z_W-1:0]    zptr_i,
  input  logic [PC_W-1:0]   ret_i,
  input  logic [7:0]        sreg_i,
  input  logic [2:0]        sel_i,
  input  logic              tbit_i,
  input  logic              two_word_i,
  output logic              valid_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              taken_o,
  output logic [2:0]        cycles_o,
  output logic              irq_en_set_o
);

  pc_op_e          op;
  pc_src_e         src;
  logic            cond, taken_d, irq_d;
  logic [2:0]      cycles_d;
  logic [PC_W-1:0] jrel, brel, seq, skip1, skip2, zpc, pc_d;

  assign op = pc_op_e'(op_i);

  generate
    if (Z_W > PC_W) begin : g_zcut
      logic unused_zhi;
      assign unused_zhi = ^zptr_i[Z_W-1:PC_W];
      assign zpc = zptr_i[PC_W-1:0];
    end else begin : g_zext
      assign zpc = PC_W'(zptr_i);
    end
  endgenerate

  pc_nxt_target #(.PC_W(PC_W), .JREL_W(JREL_W), .BREL_W(BREL_W)) u_target (
    .pc_i   (pc_i),
    .off_i  (off_i),
    .jrel_o (jrel),
    .brel_o (brel),
    .seq_o  (seq),
    .skip1_o(skip1),
    .skip2_o(skip2)
  );

  pc_nxt_cond u_cond (
    .op_i  (op),
    .sreg_i(sreg_i),
    .sel_i (sel_i),
    .tbit_i(tbit_i),
    .cond_o(cond)
  );

  pc_nxt_cost u_cost (
    .op_i      (op),
    .cond_i    (cond),
    .two_word_i(two_word_i),
    .src_o     (src),
    .cycles_o  (cycles_d),
    .taken_o   (taken_d),
    .irq_o     (irq_d)
  );

  always_comb begin
    unique case (src)
      SRC_JREL:  pc_d = jrel;
      SRC_BREL:  pc_d = brel;
      SRC_Z:     pc_d = zpc;
      SRC_ABS:   pc_d = abs_i;
      SRC_RET:   pc_d = ret_i;
      SRC_SKIP1: pc_d = skip1;
      SRC_SKIP2: pc_d = skip2;
      default:   pc_d = seq;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      next_pc_o    <= '0;
      taken_o      <= 1'b0;
      cycles_o     <= '0;
      irq_en_set_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        next_pc_o    <= pc_d;
        taken_o      <= taken_d;
        cycles_o     <= cycles_d;
        irq_en_set_o <= irq_d;
      end
    end
  end

  assert_indirect_z_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 4'd2 || op_i == 4'd3) |=> next_pc_o == $past(zpc));

  assert_reti_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd7 |=> irq_en_set_o && taken_o && cycles_o == 3'd4);

  assert_untaken_seq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (taken_o || (next_pc_o == $past(pc_i) + PC_W'(1) && cycles_o == 3'd1)));

  assert_skip_two_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd12 && tbit_i && two_word_i
      |=> next_pc_o == $past(pc_i) + PC_W'(3) && cycles_o == 3'd3);

  assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_cost_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cycles_o >= 3'd1 && cycles_o <= 3'd4);

endmodule

// File: tb/pc_nxt_unit_test.sv
module pc_nxt_unit_test;
  import pc_nxt_pkg::*;

  localparam int PC_W = 14;

  typedef struct packed {
    logic [3:0]      op;
    logic [PC_W-1:0] pc;
    logic [11:0]     off;
    logic [PC_W-1:0] abs_t;
    logic [15:0]     z;
    logic [PC_W-1:0] ret;
    logic [7:0]      sreg;
    logic [2:0]      sel;
    logic            tbit;
    logic            two;
    logic [PC_W-1:0] epc;
    logic            etk;
    logic [2:0]      ecyc;
    logic            eirq;
    logic [7:0]      rq;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    // R1 relative jump/call
    '{4'd0, 14'h0100, 12'h010, 14'h0, 16'h0, 14'h0, 8'h00, 3'd0, 1'b0, 1'b0, 14'h0111, 1'b1, 3'd2, 1'b0, 8'd1},
    '{4'd0, 14'h0100, 12'hFFF, 14'h0, 16'h0, 14'h0, 8'h00, 3'd0, 1'b0, 1'b0, 14'h0100, 1'b1, 3'd2, 1'b0, 8'd1},
    '{4'd0, 14'h0000, 12'h800, 14'h0, 16'h0, 14'h0, 8'h00, 3'd0, 1'b0, 1'b0, 14'h3801, 1'b1, 3'd2, 1'b0, 8'd1},
    '{4'd1, 14'h0200, 12'h7FF, 14'h0, 16'h0, 14'h0, 8'h00, 3'd0, 1'b0, 1'b0, 14'h0A00, 1'b1, 3'd3, 1'b0, 8'd1},
    // R2 indirect
    '{4'd2, 14'h0100, 12'h555, 14'h0, 16'h1234, 14'h0, 8'h00, 3'd0, 1'b0, 1'b0, 14'h1234, 1'b1, 3'd2, 1'b0, 8'd2},
    '{4'd3, 14'h0100, 12'h000, 14'h0, 16'hC234, 14'h0, 8'h00, 3'd0, 1'b0, 1'b0, 14'h0234, 1'b1, 3'd3, 1'b0, 8'd2},
    // R3 absolute
    '{4'd4, 14'h0100, 12'h000, 14'h2ABC, 16'h0, 14'h0, 8'h00, 3'd0, 1'b0, 1'b0, 14'h2ABC, 1'b1, 3'd3, 1'b0, 8'd3},
    '{4'd5, 14'h0100, 12'h000, 14'h0042, 16'h0, 14'h0, 8'h00, 3'd0, 1'b0, 1'b0, 14'h0042, 1'b1, 3'd4, 1'b0, 8'd3},
    // R4 return, R5 return from interrupt
    '{4'd6, 14'h0100, 12'h000, 14'h0, 16'h0, 14'h1357, 8'h00, 3'd0, 1'b0, 1'b0, 14'h1357, 1'b1, 3'd4, 1'b0, 8'd4},
    '{4'd7, 14'h0100, 12'h000, 14'h0, 16'h0, 14'h0ABC, 8'h00, 3'd0, 1'b0, 1'b0, 14'h0ABC, 1'b1, 3'd4, 1'b1, 8'd5},
    // R6 branch on status bit, upper offset bits ignored
    '{4'd8, 14'h0300, 12'hF3F, 14'h0, 16'h0, 14'h0, 8'h02, 3'd1, 1'b0, 1'b0, 14'h0340, 1'b1, 3'd2, 1'b0, 8'd6},
    '{4'd8, 14'h0300, 12'h03F, 14'h0, 16'h0, 14'h0, 8'hFD, 3'd1, 1'b0, 1'b0, 14'h0301, 1'b0, 3'd1, 1'b0, 8'd6},
    '{4'd9, 14'h0300, 12'h040, 14'h0, 16'h0, 14'h0, 8'hFE, 3'd0, 1'b0, 1'b0, 14'h02C1, 1'b1, 3'd2, 1'b0, 8'd6},
    '{4'd9, 14'h0300, 12'h040, 14'h0, 16'h0, 14'h0, 8'h01, 3'd0, 1'b0, 1'b0, 14'h0301, 1'b0, 3'd1, 1'b0, 8'd6},
    '{4'd8, 14'h0300, 12'h001, 14'h0, 16'h0, 14'h0, 8'hBF, 3'd6, 1'b0, 1'b0, 14'h0301, 1'b0, 3'd1, 1'b0, 8'd6},
    '{4'd8, 14'h0300, 12'h001, 14'h0, 16'h0, 14'h0, 8'h40, 3'd6, 1'b0, 1'b0, 14'h0302, 1'b1, 3'd2, 1'b0, 8'd6},
    // R7 signed compare branches
    '{4'd10, 14'h0010, 12'h005, 14'h0, 16'h0, 14'h0, 8'h0C, 3'd0, 1'b0, 1'b0, 14'h0016, 1'b1, 3'd2, 1'b0, 8'd7},
    '{4'd10, 14'h0010, 12'h005, 14'h0, 16'h0, 14'h0, 8'h04, 3'd0, 1'b0, 1'b0, 14'h0011, 1'b0, 3'd1, 1'b0, 8'd7},
    '{4'd11, 14'h0010, 12'h005, 14'h0, 16'h0, 14'h0, 8'h08, 3'd0, 1'b0, 1'b0, 14'h0016, 1'b1, 3'd2, 1'b0, 8'd7},
    '{4'd11, 14'h0010, 12'h005, 14'h0, 16'h0, 14'h0, 8'hF3, 3'd0, 1'b0, 1'b0, 14'h0011, 1'b0, 3'd1, 1'b0, 8'd7},
    // R8 skips
    '{4'd12, 14'h0500, 12'h000, 14'h0, 16'h0, 14'h0, 8'h00, 3'd0, 1'b1, 1'b0, 14'h0502, 1'b1, 3'd2, 1'b0, 8'd8},
    '{4'd12, 14'h0500, 12'h000, 14'h0, 16'h0, 14'h0, 8'h00, 3'd0, 1'b1, 1'b1, 14'h0503, 1'b1, 3'd3, 1'b0, 8'd8},
    '{4'd12, 14'h0500, 12'h000, 14'h0, 16'h0, 14'h0, 8'hFF, 3'd0, 1'b0, 1'b1, 14'h0501, 1'b0, 3'd1, 1'b0, 8'd8},
    '{4'd13, 14'h0500, 12'h000, 14'h0, 16'h0, 14'h0, 8'h00, 3'd0, 1'b0, 1'b1, 14'h0503, 1'b1, 3'd3, 1'b0, 8'd8},
    '{4'd13, 14'h0500, 12'h000, 14'h0, 16'h0, 14'h0, 8'h00, 3'd0, 1'b1, 1'b0, 14'h0501, 1'b0, 3'd1, 1'b0, 8'd8},
    '{4'd12, 14'h3FFF, 12'h000, 14'h0, 16'h0, 14'h0, 8'h00, 3'd0, 1'b1, 1'b1, 14'h0002, 1'b1, 3'd3, 1'b0, 8'd8}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid = 1'b0;
  logic [3:0]        op = '0;
  logic [PC_W-1:0]   pc = '0, abs_t = '0, ret = '0;
  logic [11:0]       off = '0;
  logic [15:0]       z = '0;
  logic [7:0]        sreg = '0;
  logic [2:0]        sel = '0;
  logic              tbit = 1'b0, two = 1'b0;
  logic              valid_o, taken_o, irq_o;
  logic [PC_W-1:0]   npc_o;
  logic [2:0]        cyc_o;
  int                n_chk = 0, n_err = 0;
  logic              done = 1'b0;

  always #5 clk = ~clk;

  pc_nxt_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .pc_i(pc),
    .off_i(off), .abs_i(abs_t), .zptr_i(z), .ret_i(ret), .sreg_i(sreg),
    .sel_i(sel), .tbit_i(tbit), .two_word_i(two), .valid_o(valid_o),
    .next_pc_o(npc_o), .taken_o(taken_o), .cycles_o(cyc_o),
    .irq_en_set_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    valid = 1'b1; op = v.op; pc = v.pc; off = v.off; abs_t = v.abs_t;
    z = v.z; ret = v.ret; sreg = v.sreg; sel = v.sel; tbit = v.tbit; two = v.two;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset valid", 32'(valid_o), 0);
    chk("R9 reset pc", 32'(npc_o), 0);
    chk("R9 reset cycles", 32'(cyc_o), 0);
    chk("R9 reset taken/irq", 32'({taken_o, irq_o}), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      chk($sformatf("R%0d vec%0d valid", VECS[i].rq, i), 32'(valid_o), 1);
      chk($sformatf("R%0d vec%0d pc", VECS[i].rq, i), 32'(npc_o), 32'(VECS[i].epc));
      chk($sformatf("R%0d vec%0d taken", VECS[i].rq, i), 32'(taken_o), 32'(VECS[i].etk));
      chk($sformatf("R%0d vec%0d cycles", VECS[i].rq, i), 32'(cyc_o), 32'(VECS[i].ecyc));
      chk($sformatf("R%0d vec%0d irq", VECS[i].rq, i), 32'(irq_o), 32'(VECS[i].eirq));
    end

    // R9 no request: valid_o drops, outputs hold
    @(negedge clk);
    chk("R9 idle valid", 32'(valid_o), 0);

    // R10 undefined op codes
    drive('{4'd14, 14'h0777, 12'h123, 14'h1111, 16'h2222, 14'h3333, 8'hFF, 3'd0, 1'b1, 1'b1,
            14'h0778, 1'b1, 3'd1, 1'b0, 8'd10});
    chk("R10 op14 pc", 32'(npc_o), 32'h0778);
    chk("R10 op14 taken", 32'(taken_o), 0);
    chk("R10 op14 cycles", 32'(cyc_o), 1);
    drive('{4'd15, 14'h3FFF, 12'h000, 14'h0, 16'h0, 14'h0, 8'h00, 3'd0, 1'b0, 1'b0,
            14'h0, 1'b0, 3'd1, 1'b0, 8'd10});
    chk("R10 op15 pc wrap", 32'(npc_o), 0);
    chk("R10 op15 cycles", 32'(cyc_o), 1);

    // R5 then R4: irq flag follows the latest request
    drive('{4'd7, 14'h0, 12'h0, 14'h0, 16'h0, 14'h0123, 8'h00, 3'd0, 1'b0, 1'b0,
            14'h0123, 1'b1, 3'd4, 1'b1, 8'd5});
    chk("R5 reti irq", 32'(irq_o), 1);
    drive('{4'd6, 14'h0, 12'h0, 14'h0, 16'h0, 14'h0456, 8'h00, 3'd0, 1'b0, 1'b0,
            14'h0456, 1'b1, 3'd4, 1'b0, 8'd4});
    chk("R4 ret irq low", 32'(irq_o), 0);
    chk("R4 ret pc", 32'(npc_o), 32'h0456);

    // R9 reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset pc", 32'(npc_o), 0);
    chk("R9 async reset cycles", 32'(cyc_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule